// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block controls a bank of sixteen general-purpose pins through a 32-bit register window. The window uses a plain synchronous bus: byte address, write strobe, read strobe and write data. Read data is registered and is valid in the cycle after the read strobe. Each pin has a stored configuration: a drive mode, an output style, a speed grade, a pull choice and a 4-bit selector for alternate functions. From these the block produces each pad's output level and output enable.

Pin levels are brought in through a two-flop synchronizer and can be read from an input word. A write-only set/clear word changes single output bits without a read-modify-write. The configuration of chosen pins can be frozen by a keyed write sequence. Once armed, the freeze lasts until reset. Speed and pull values drive no pad logic here. They are only held and exported to the pad ring.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads zero, all pads have output enable low and their output level low.
- R2: Each configuration word reads back what was last written: drive mode at byte 0x00, output style at 0x04 (bits 15:0 only), speed at 0x08, pull at 0x0C, output latch at 0x14, and alternate selectors at 0x20 and 0x24. Read data appears the cycle after the read strobe.
- R3: A write to 0x18 sets latch bit y when data bit y is 1 and clears it when data bit 16+y is 1. When both are 1 the set wins. Zero bits leave the latch unchanged, and a read of 0x18 returns zero.
- R4: Byte 0x10 returns the pad levels in bits 15:0 after two clock stages of synchronization. Writes to it have no effect.
- R5: The drive mode is 2 bits per pin at bit 2*pin: 0 input, 1 latch-driven output, 2 alternate function, 3 analog. Output enable is high only in modes 1 and 2. In mode 1 the pad level equals the latch bit.
- R6: In mode 2 the pad level is `alt_src[16*pin + sel]`. Pins 0-7 take `sel` from byte 0x20 at bit 4*pin, and pins 8-15 take it from byte 0x24 at bit 4*(pin-8).
- R7: When the output-style bit is 1 (open drain), the pad output level is always 0 and output enable is high only while the selected value is 0. When the bit is 0 (push-pull), the pad drives the value.
- R8: `cfg_speed` and `cfg_pull` carry the stored speed and pull words, 2 bits per pin at bit 2*pin.
- R9: Lock word 0x1C, with the pin mask in bits 15:0 and the key in bit 16, is armed by three writes with key 1, 0, 1 and the same mask, followed by a read of 0x1C. That read still shows key 0. Afterwards bit 16 reads 1, and the mask and the mode, style, speed, pull and selector fields of masked pins ignore writes until reset. Unmasked fields and the latch stay writable.
- R10: A lock sequence broken by a different mask does not arm the lock.
- R11: Reads of byte offsets outside the map, including misaligned ones, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Pad input levels |
| alt_src | input | 256 | Sixteen alternate sources per pin |
| pin_out | output | 16 | Pad output levels |
| pin_oe | output | 16 | Pad output enables |
| cfg_speed | output | 32 | Stored speed grades |
| cfg_pull | output | 32 | Stored pull choices |

## Verification
The set/clear word is driven with set-only, clear-only, set-and-clear on one bit, and all-zero patterns. These tell priority apart from plain overwrite and from a stray effect of zeros. The pads are tried with one pin in each of the four modes, with alternate pins in both selector words, and with each output style on a latch that is high and then low. This separates the latch path from the selector path and the low-word pins from the high-word pins. The lock is tried with a broken sequence and with a clean one, then with writes of all ones and all zeros. This shows that only masked fields are frozen.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    PM_IN  = 2'd0,
    PM_OUT = 2'd1,
    PM_ALT = 2'd2,
    PM_ANA = 2'd3
  } pin_mode_e;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ARM1,
    LK_ARM0,
    LK_ARM2,
    LK_DONE
  } lock_state_e;

  // word indices (byte offset / 4)
  localparam int W_MODE   = 0;
  localparam int W_STYLE  = 1;
  localparam int W_SPEED  = 2;
  localparam int W_PULL   = 3;
  localparam int W_IN     = 4;
  localparam int W_LATCH  = 5;
  localparam int W_SETCLR = 6;
  localparam int W_LOCK   = 7;
  localparam int W_AFLO   = 8;
  localparam int W_AFHI   = 9;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;

endmodule

// File: rtl/gpio_bank_pin.sv
module gpio_bank_pin
  import gpio_bank_pkg::*;
#(
  parameter int AF_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 open_drain,
  input  logic                 latch,
  input  logic [AF_W-1:0]      af_sel,
  input  logic [(1<<AF_W)-1:0] alt_vec,
  output logic                 pad_out,
  output logic                 pad_oe
);

  pin_mode_e m;
  logic      drive_en;
  logic      level;

  assign m        = pin_mode_e'(mode);
  assign drive_en = (m == PM_OUT) || (m == PM_ALT);
  assign level    = (m == PM_ALT) ? alt_vec[af_sel] : latch;

  // open drain: never drives high, only pulls low
  assign pad_oe  = drive_en & (~open_drain | ~level);
  assign pad_out = drive_en & ~open_drain & level;

  assert_oe_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (m == PM_OUT || m == PM_ALT));

  assert_od_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    open_drain |-> !pad_out);

endmodule

// File: rtl/gpio_bank_lock.sv
module gpio_bank_lock
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock_wr,
  input  logic                lock_rd,
  input  logic                key_bit,
  input  logic [NUM_PINS-1:0] mask,
  output logic [NUM_PINS-1:0] lck,
  output logic                key_active
);

  lock_state_e       st_q, st_d;
  logic [NUM_PINS-1:0] lck_q;
  logic              same_mask;
  lock_state_e       restart;

  assign same_mask = (mask == lck_q);
  assign restart   = key_bit ? LK_ARM1 : LK_IDLE;

  always_comb begin
    st_d = st_q;
    if (st_q != LK_DONE) begin
      if (lock_wr) begin
        case (st_q)
          LK_ARM1: st_d = (!key_bit && same_mask) ? LK_ARM0 : restart;
          LK_ARM0: st_d = (key_bit && same_mask) ? LK_ARM2 : restart;
          default: st_d = restart;
        endcase
      end else if (lock_rd && st_q == LK_ARM2) begin
        st_d = LK_DONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= LK_IDLE;
      lck_q <= '0;
    end else begin
      st_q <= st_d;
      if (lock_wr && st_q != LK_DONE) lck_q <= mask;
    end
  end

  assign lck        = lck_q;
  assign key_active = (st_q == LK_DONE);

  assert_key_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_active |=> key_active);

  assert_mask_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_active |=> $stable(lck_q));

  assert_no_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_IDLE) |=> (st_q != LK_DONE));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int AF_W     = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic                          bus_re,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_PINS-1:0]           pin_in,
  input  logic [NUM_PINS*(1<<AF_W)-1:0] alt_src,
  output logic [NUM_PINS-1:0]           pin_out,
  output logic [NUM_PINS-1:0]           pin_oe,
  output logic [2*NUM_PINS-1:0]         cfg_speed,
  output logic [2*NUM_PINS-1:0]         cfg_pull
);

  // layout assumes 2*NUM_PINS == DATA_W and two selector words
  localparam int AF_N   = 1 << AF_W;
  localparam int W2     = 2 * NUM_PINS;
  localparam int WAF    = AF_W * NUM_PINS;
  localparam int WIDX_W = ADDR_W - 2;

  // ---------------- merge arithmetic ----------------
  function automatic logic [DATA_W-1:0] merge_word(
    input logic [DATA_W-1:0] old_v, input logic [DATA_W-1:0] new_v,
    input logic [DATA_W-1:0] keep);
    return (old_v & keep) | (new_v & ~keep);
  endfunction

  function automatic logic [NUM_PINS-1:0] merge_pins(
    input logic [NUM_PINS-1:0] old_v, input logic [NUM_PINS-1:0] new_v,
    input logic [NUM_PINS-1:0] keep);
    return (old_v & keep) | (new_v & ~keep);
  endfunction

  function automatic logic [NUM_PINS-1:0] apply_setclr(
    input logic [NUM_PINS-1:0] cur, input logic [NUM_PINS-1:0] set_m,
    input logic [NUM_PINS-1:0] clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

  // ---------------- decode ----------------
  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic wr_mode, wr_style, wr_speed, wr_pull, wr_latch, sr_wr;
  logic wr_lock, rd_lock, wr_aflo, wr_afhi;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  assign wr_mode  = bus_we & aligned & (widx == WIDX_W'(W_MODE));
  assign wr_style = bus_we & aligned & (widx == WIDX_W'(W_STYLE));
  assign wr_speed = bus_we & aligned & (widx == WIDX_W'(W_SPEED));
  assign wr_pull  = bus_we & aligned & (widx == WIDX_W'(W_PULL));
  assign wr_latch = bus_we & aligned & (widx == WIDX_W'(W_LATCH));
  assign sr_wr    = bus_we & aligned & (widx == WIDX_W'(W_SETCLR));
  assign wr_lock  = bus_we & aligned & (widx == WIDX_W'(W_LOCK));
  assign wr_aflo  = bus_we & aligned & (widx == WIDX_W'(W_AFLO));
  assign wr_afhi  = bus_we & aligned & (widx == WIDX_W'(W_AFHI));
  assign rd_lock  = bus_re & aligned & (widx == WIDX_W'(W_LOCK));

  logic [NUM_PINS-1:0] sr_set, sr_clr;
  assign sr_set = bus_wdata[NUM_PINS-1:0];
  assign sr_clr = bus_wdata[2*NUM_PINS-1:NUM_PINS];

  // ---------------- lock ----------------
  logic [NUM_PINS-1:0] lck;
  logic                key_active;
  logic [NUM_PINS-1:0] keep1;
  logic [W2-1:0]       keep2;
  logic [WAF-1:0]      keep4;

  gpio_bank_lock #(.NUM_PINS(NUM_PINS)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_wr   (wr_lock),
    .lock_rd   (rd_lock),
    .key_bit   (bus_wdata[NUM_PINS]),
    .mask      (bus_wdata[NUM_PINS-1:0]),
    .lck       (lck),
    .key_active(key_active)
  );

  assign keep1 = key_active ? lck : '0;

  // ---------------- configuration state ----------------
  logic [W2-1:0]       mode_q, speed_q, pull_q;
  logic [NUM_PINS-1:0] style_q, latch_q;
  logic [WAF-1:0]      af_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      style_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      latch_q <= '0;
      af_q    <= '0;
    end else begin
      if (wr_mode)  mode_q  <= merge_word(mode_q, bus_wdata, keep2);
      if (wr_style) style_q <= merge_pins(style_q, bus_wdata[NUM_PINS-1:0], keep1);
      if (wr_speed) speed_q <= merge_word(speed_q, bus_wdata, keep2);
      if (wr_pull)  pull_q  <= merge_word(pull_q, bus_wdata, keep2);
      if (wr_latch)   latch_q <= bus_wdata[NUM_PINS-1:0];
      else if (sr_wr) latch_q <= apply_setclr(latch_q, sr_set, sr_clr);
      if (wr_aflo)
        af_q[DATA_W-1:0] <= merge_word(af_q[DATA_W-1:0], bus_wdata, keep4[DATA_W-1:0]);
      if (wr_afhi)
        af_q[WAF-1:DATA_W] <= merge_word(af_q[WAF-1:DATA_W], bus_wdata, keep4[WAF-1:DATA_W]);
    end
  end

  // ---------------- input sampling ----------------
  logic [NUM_PINS-1:0] idr_s;

  gpio_bank_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (idr_s)
  );

  // ---------------- per-pin drive ----------------
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign keep2[2*p +: 2]       = {2{keep1[p]}};
    assign keep4[AF_W*p +: AF_W] = {AF_W{keep1[p]}};

    gpio_bank_pin #(.AF_W(AF_W)) u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_q[2*p +: 2]),
      .open_drain(style_q[p]),
      .latch     (latch_q[p]),
      .af_sel    (af_q[AF_W*p +: AF_W]),
      .alt_vec   (alt_src[AF_N*p +: AF_N]),
      .pad_out   (pin_out[p]),
      .pad_oe    (pin_oe[p])
    );
  end

  assign cfg_speed = speed_q;
  assign cfg_pull  = pull_q;

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_word;
  logic              rd_hit;
  logic              rd_unmapped;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_word = '0;
    rd_hit  = aligned;
    case (widx)
      WIDX_W'(W_MODE):   rd_word = mode_q;
      WIDX_W'(W_STYLE):  rd_word = DATA_W'(style_q);
      WIDX_W'(W_SPEED):  rd_word = speed_q;
      WIDX_W'(W_PULL):   rd_word = pull_q;
      WIDX_W'(W_IN):     rd_word = DATA_W'(idr_s);
      WIDX_W'(W_LATCH):  rd_word = DATA_W'(latch_q);
      WIDX_W'(W_SETCLR): rd_word = '0;
      WIDX_W'(W_LOCK):   rd_word = DATA_W'({key_active, lck});
      WIDX_W'(W_AFLO):   rd_word = af_q[DATA_W-1:0];
      WIDX_W'(W_AFHI):   rd_word = af_q[WAF-1:DATA_W];
      default:           rd_hit  = 1'b0;
    endcase
    if (!aligned) rd_word = '0;
  end

  assign rd_unmapped = bus_re & ~rd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;

  // ---------------- assertions ----------------
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr |=> ((latch_q & $past(sr_set)) == $past(sr_set)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr |=> ((latch_q & $past(sr_clr & ~sr_set)) == '0));

  assert_locked_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_active && wr_mode) |=> ((mode_q & keep2) == $past(mode_q & keep2)));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (bus_rdata == '0));

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [5:0]   bus_addr;
  logic         bus_we, bus_re;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [15:0]  pin_in, pin_out, pin_oe;
  logic [255:0] alt_src;
  logic [31:0]  cfg_speed, cfg_pull;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .alt_src(alt_src), .pin_out(pin_out), .pin_oe(pin_oe),
    .cfg_speed(cfg_speed), .cfg_pull(cfg_pull)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read data valid the cycle after the strobe
  always @(posedge clk) pend <= bus_re;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R2 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 50000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_re = 1'b0;
    bus_wdata = '0; pin_in = '0; alt_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", {16'h0, pin_oe}, 32'h0);
    chk("R1 out", {16'h0, pin_out}, 32'h0);
    for (int i = 0; i < 10; i++) rd(6'(i*4), 32'h0, "R1 reset read");

    // R2 readback, R8 export
    wr(6'h08, 32'hDEAD_BEEF);
    wr(6'h0C, 32'h1234_5678);
    wr(6'h04, 32'hFFFF_00F0);
    wr(6'h20, 32'h7654_3210);
    wr(6'h24, 32'hFEDC_BA98);
    rd(6'h08, 32'hDEAD_BEEF, "R2 speed");
    rd(6'h0C, 32'h1234_5678, "R2 pull");
    rd(6'h04, 32'h0000_00F0, "R2 style");
    rd(6'h20, 32'h7654_3210, "R2 af low");
    rd(6'h24, 32'hFEDC_BA98, "R2 af high");
    chk("R8 speed", cfg_speed, 32'hDEAD_BEEF);
    chk("R8 pull", cfg_pull, 32'h1234_5678);
    wr(6'h04, 32'h0);

    // R3 set/clear on all-output port, R5 latch drive
    wr(6'h00, 32'h5555_5555);
    wr(6'h14, 32'h0000_00FF);
    chk("R5 out", {16'h0, pin_out}, 32'h0000_00FF);
    chk("R5 oe", {16'h0, pin_oe}, 32'h0000_FFFF);
    wr(6'h18, 32'h000F_0300);
    chk("R3 set+clr", {16'h0, pin_out}, 32'h0000_03F0);
    wr(6'h18, 32'h0001_0001);
    chk("R3 set wins", {16'h0, pin_out}, 32'h0000_03F1);
    wr(6'h18, 32'h0);
    rd(6'h14, 32'h0000_03F1, "R3 zeros no effect");
    rd(6'h18, 32'h0, "R3 write-only");

    // R4 input sampling
    pin_in = 16'hA5C3;
    idle(3);
    rd(6'h10, 32'h0000_A5C3, "R4 input");
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, 32'h0000_A5C3, "R4 read-only");
    pin_in = 16'h1111;
    rd(6'h10, 32'h0000_A5C3, "R4 sync lag");
    idle(2);
    rd(6'h10, 32'h0000_1111, "R4 sync settled");

    // R5/R6 modes and alternate selection
    wr(6'h14, 32'h0000_000F);
    alt_src = '0; alt_src[34] = 1'b1;
    wr(6'h00, 32'h0000_00E4);
    chk("R5 mode oe", {16'h0, pin_oe}, 32'h0000_0006);
    chk("R6 alt low", {16'h0, pin_out}, 32'h0000_0006);
    alt_src = '0; alt_src[153] = 1'b1;
    wr(6'h00, 32'h0008_00E4);
    chk("R6 alt high", {16'h0, pin_out}, 32'h0000_0202);
    chk("R6 alt oe", {16'h0, pin_oe}, 32'h0000_0206);

    // R7 open drain
    wr(6'h04, 32'h0000_0002);
    chk("R7 od high out", {16'h0, pin_out}, 32'h0000_0200);
    chk("R7 od high oe", {16'h0, pin_oe}, 32'h0000_0204);
    wr(6'h18, 32'h0002_0000);
    chk("R7 od low out", {16'h0, pin_out}, 32'h0000_0200);
    chk("R7 od low oe", {16'h0, pin_oe}, 32'h0000_0206);

    // R10 broken sequence
    wr(6'h1C, 32'h0001_0003);
    wr(6'h1C, 32'h0000_0005);
    wr(6'h1C, 32'h0001_0003);
    rd(6'h1C, 32'h0000_0003, "R10 broken read");
    rd(6'h1C, 32'h0000_0003, "R10 not armed");

    // R9 clean sequence
    wr(6'h1C, 32'h0001_0003);
    wr(6'h1C, 32'h0000_0003);
    wr(6'h1C, 32'h0001_0003);
    rd(6'h1C, 32'h0000_0003, "R9 arming read");
    rd(6'h1C, 32'h0001_0003, "R9 key active");
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h04, 32'h0000_FFFF);
    wr(6'h08, 32'h0);
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h20, 32'h0);
    wr(6'h24, 32'h0);
    wr(6'h1C, 32'h0);
    wr(6'h14, 32'h0000_AAAA);
    rd(6'h00, 32'hFFFF_FFF4, "R9 mode locked");
    rd(6'h04, 32'h0000_FFFE, "R9 style locked");
    rd(6'h08, 32'h0000_000F, "R9 speed locked");
    rd(6'h0C, 32'hFFFF_FFF8, "R9 pull locked");
    rd(6'h20, 32'h0000_0010, "R9 af low locked");
    rd(6'h24, 32'h0, "R9 af high free");
    rd(6'h1C, 32'h0001_0003, "R9 mask frozen");
    rd(6'h14, 32'h0000_AAAA, "R9 latch free");
    chk("R9 speed export", cfg_speed, 32'h0000_000F);

    // R11 unmapped
    rd(6'h28, 32'h0, "R11 past map");
    rd(6'h3C, 32'h0, "R11 top");
    rd(6'h02, 32'h0, "R11 misaligned");

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R2 missing read data actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule